// File: doc/BRIEF.md
# Multiplexed Handshaked Bus Master

This block is the master side of a parallel bus on which one set of sixteen lines carries first the byte address of a cycle and then its data. A local requester hands it one request at a time: read or write, byte or word size, a byte address, a write word and a burst length. The block then runs a single address phase followed by one or more data phases. Each data phase finishes only when the addressed slave raises its reply line, so the cycle's length is set by the slave rather than by a fixed wait count.

The reply line arrives from another timing domain and passes through a two-stage synchronizer before the control logic acts on it. After each accepted reply the data strobe is removed and the block waits for the reply to drop before it opens the next phase. In a burst the address advances inside the slave by one byte or by one word per phase, and no new address phase is sent. A timeout counter that restarts at every phase abandons a stalled cycle and reports an error, together with the number of phases that had completed.

Top module: `mxbus_master`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While the address strobe is high, `req_ready` stays low.
- R2: The first bus state after a request is taken is the address phase. In it `bus_out` carries the request address, `bus_oe` is high, `adr_stb_o` is high and `dat_stb_o` is low.
- R3: The same lines then carry data. `dat_stb_o` is high only while `adr_stb_o` is high. While the data strobe is high, `bus_oe` equals `dir_wr_o`: it drives the lines for a write and releases them for a read.
- R4: A data phase ends on the synchronized reply. The data strobe stays high until the reply is seen, unless the phase times out. A new data strobe never rises while the raw reply is still high.
- R5: Byte lanes follow address bit 0. A value of 0 selects bits [7:0] and a value of 1 selects bits [15:8]. On a byte write the unused lane is driven to zero. A byte read is returned in `rd_data[7:0]` with the upper byte zero. A word transfer uses all 16 bits.
- R6: A request with `req_len` = N makes one address phase and N+1 data phases. The slave-side address advances by 1 per phase for bytes and by 2 for words. A burst write repeats the request word (its low byte for byte bursts). On success `done_beats` is N+1 and `done_err` is 0.
- R7: If the data strobe stays high for TMO_CYCLES clocks without a reply, the cycle is abandoned. `done_err` is then 1 and `done_beats` holds the number of completed phases. The counter restarts at every phase, so a burst whose total length exceeds the limit still succeeds.
- R8: A word request with address bit 0 set ends with `done_err` = 1 and `done_beats` = 0. No address strobe is raised for it.
- R9: Every completed read phase gives one `rd_valid` pulse carrying that phase's data, in address order. Writes give no `rd_valid` pulse.
- R10: After reset the block is idle: `req_ready` = 1, and all strobes, `bus_oe`, `done` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte size, 0 = word size |
| req_addr | input | 16 | Starting byte address |
| req_wdata | input | 16 | Write word (low byte used for byte writes) |
| req_len | input | LEN_W | Number of data phases minus one |
| rd_valid | output | 1 | One-cycle pulse per completed read phase |
| rd_data | output | 16 | Read data, lane-aligned |
| done | output | 1 | One-cycle pulse when the cycle ends |
| done_err | output | 1 | Cycle ended by timeout or misalignment |
| done_beats | output | LEN_W+1 | Data phases completed |
| bus_out | output | 16 | Value driven onto the shared lines |
| bus_oe | output | 1 | Drive enable for the shared lines |
| bus_in | input | 16 | Value sampled from the shared lines |
| adr_stb_o | output | 1 | Address strobe, held for the whole cycle |
| dat_stb_o | output | 1 | Data strobe |
| dir_wr_o | output | 1 | Transfer direction, 1 = write |
| byte_o | output | 1 | Byte-size qualifier |
| ack_i | input | 1 | Slave reply, asynchronous |

## Verification
The bench builds the block with TMO_CYCLES = 12 and LEN_W = 3. A short limit makes both timeout cases cheap to reach: a slave that never replies, and a burst that goes silent after two phases. It also lets a six-clock reply delay make a four-phase burst run past the limit in total while each single phase stays inside it, which tests the per-phase restart. The three-bit length still allows bursts long enough to cross word boundaries with byte steps.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

    localparam int BUS_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DSTB,
        ST_WAIT,
        ST_RECOV,
        ST_REL
    } mst_state_e;

    typedef struct packed {
        logic             wr;
        logic             bsz;
        logic [BUS_W-1:0] addr;
        logic [BUS_W-1:0] wdata;
    } xfer_t;

    // Place write data into the lane chosen by address bit 0.
    function automatic logic [BUS_W-1:0] lane_place(
        input logic [BUS_W-1:0] w, input logic bsz, input logic a0);
        if (!bsz) return w;
        if (a0)   return {w[BYTE_W-1:0], {BYTE_W{1'b0}}};
        return {{BYTE_W{1'b0}}, w[BYTE_W-1:0]};
    endfunction

    // Pull the addressed lane down to the low byte.
    function automatic logic [BUS_W-1:0] lane_pick(
        input logic [BUS_W-1:0] raw, input logic bsz, input logic a0);
        if (!bsz) return raw;
        if (a0)   return {{BYTE_W{1'b0}}, raw[BUS_W-1:BYTE_W]};
        return {{BYTE_W{1'b0}}, raw[BYTE_W-1:0]};
    endfunction

    function automatic logic [BUS_W-1:0] addr_step(input logic bsz);
        return bsz ? BUS_W'(1) : BUS_W'(2);
    endfunction

endpackage

// File: rtl/mxbus_sync.sv
module mxbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/mxbus_timer.sv
module mxbus_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (run)   cnt <= cnt + CW'(1);
    end

    assign expired = run && (cnt == CW'(LIMIT - 1));

    // R7: a running phase never counts past its limit
    a_r7_timer_bounded: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < CW'(LIMIT)));
endmodule

// File: rtl/mxbus_lanes.sv
module mxbus_lanes
    import mxbus_pkg::*;
(
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] raw,
    input  logic             bsz,
    input  logic             a0,
    output logic [BUS_W-1:0] drive,
    output logic [BUS_W-1:0] pick
);
    always_comb begin
        drive = lane_place(wdata, bsz, a0);
        pick  = lane_pick(raw, bsz, a0);
    end
endmodule

// File: rtl/mxbus_master.sv
module mxbus_master
    import mxbus_pkg::*;
#(
    parameter int TMO_CYCLES = 256,
    parameter int LEN_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic             req_byte,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    input  logic [LEN_W-1:0] req_len,
    output logic             rd_valid,
    output logic [BUS_W-1:0] rd_data,
    output logic             done,
    output logic             done_err,
    output logic [LEN_W:0]   done_beats,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    input  logic [BUS_W-1:0] bus_in,
    output logic             adr_stb_o,
    output logic             dat_stb_o,
    output logic             dir_wr_o,
    output logic             byte_o,
    input  logic             ack_i
);
    localparam int BW = LEN_W + 1;

    mst_state_e       st;
    xfer_t            cur;
    logic [LEN_W-1:0] left;
    logic [LEN_W-1:0] len_q;
    logic [BW-1:0]    beats;
    logic             err_q;
    logic             rdv_q;
    logic [BUS_W-1:0] rdd_q;
    logic             ack_s;
    logic             tmo;
    logic             t_clr;
    logic             t_run;
    logic [BUS_W-1:0] drive_w;
    logic [BUS_W-1:0] pick_w;
    logic             misal;

    mxbus_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(ack_i), .q(ack_s)
    );

    assign t_clr = (st == ST_DSTB) || ((st == ST_WAIT) && ack_s);
    assign t_run = (st == ST_WAIT) || (st == ST_RECOV);

    mxbus_timer #(.LIMIT(TMO_CYCLES)) u_tmr (
        .clk(clk), .rst(rst), .clr(t_clr), .run(t_run), .expired(tmo)
    );

    mxbus_lanes u_lanes (
        .wdata(cur.wdata), .raw(bus_in), .bsz(cur.bsz), .a0(cur.addr[0]),
        .drive(drive_w), .pick(pick_w)
    );

    assign misal = !req_byte && req_addr[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cur   <= '0;
            left  <= '0;
            len_q <= '0;
            beats <= '0;
            err_q <= 1'b0;
            rdv_q <= 1'b0;
            rdd_q <= '0;
        end else begin
            rdv_q <= 1'b0;
            case (st)
                ST_IDLE: if (req_valid) begin
                    cur.wr    <= req_write;
                    cur.bsz   <= req_byte;
                    cur.addr  <= req_addr;
                    cur.wdata <= req_wdata;
                    left      <= req_len;
                    len_q     <= req_len;
                    beats     <= '0;
                    err_q     <= misal;
                    st        <= misal ? ST_REL : ST_ADDR;
                end
                ST_ADDR: st <= ST_DSTB;
                ST_DSTB: st <= ST_WAIT;
                ST_WAIT: begin
                    if (ack_s) begin
                        beats <= beats + BW'(1);
                        if (!cur.wr) begin
                            rdv_q <= 1'b1;
                            rdd_q <= pick_w;
                        end
                        st <= ST_RECOV;
                    end else if (tmo) begin
                        err_q <= 1'b1;
                        st    <= ST_REL;
                    end
                end
                ST_RECOV: begin
                    if (!ack_s) begin
                        if (left != '0) begin
                            left     <= left - LEN_W'(1);
                            cur.addr <= cur.addr + addr_step(cur.bsz);
                            st       <= ST_DSTB;
                        end else begin
                            st <= ST_REL;
                        end
                    end else if (tmo) begin
                        err_q <= 1'b1;
                        st    <= ST_REL;
                    end
                end
                ST_REL:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        adr_stb_o = 1'b0;
        dat_stb_o = 1'b0;
        bus_oe    = 1'b0;
        bus_out   = '0;
        dir_wr_o  = 1'b0;
        byte_o    = 1'b0;
        case (st)
            ST_ADDR: begin
                adr_stb_o = 1'b1;
                bus_oe    = 1'b1;
                bus_out   = cur.addr;
                dir_wr_o  = cur.wr;
                byte_o    = cur.bsz;
            end
            ST_DSTB, ST_WAIT, ST_RECOV: begin
                adr_stb_o = 1'b1;
                dat_stb_o = (st == ST_WAIT);
                bus_oe    = cur.wr;
                bus_out   = cur.wr ? drive_w : '0;
                dir_wr_o  = cur.wr;
                byte_o    = cur.bsz;
            end
            default: ;
        endcase
    end

    assign req_ready  = (st == ST_IDLE);
    assign done       = (st == ST_REL);
    assign done_err   = err_q;
    assign done_beats = beats;
    assign rd_valid   = rdv_q;
    assign rd_data    = rdd_q;

    // R1: never ready while a cycle holds the address strobe
    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        adr_stb_o |-> !req_ready);

    // R2: address phase carries the accepted address with lines driven
    a_r2_addr_phase: assert property (@(posedge clk) disable iff (rst)
        $rose(adr_stb_o) |-> (bus_oe && !dat_stb_o && bus_out == $past(req_addr)));

    // R3: data strobe nested in address strobe, drive follows direction
    a_r3_ds_in_as: assert property (@(posedge clk) disable iff (rst)
        dat_stb_o |-> (adr_stb_o && bus_oe == dir_wr_o));

    // R4: data strobe drops only on a seen reply or an abort
    a_r4_ds_drop_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(dat_stb_o) |-> ($past(ack_s) || (done && done_err)));

    // R6: completed phases never exceed the requested count
    a_r6_beats_bound: assert property (@(posedge clk) disable iff (rst)
        done |-> (done_beats <= (BW'(len_q) + BW'(1))));

    // R8: misaligned word request ends at once with no bus activity
    a_r8_misaligned: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && misal) |=> (done && done_err && done_beats == '0 && !adr_stb_o));
endmodule

// File: tb/sim_mxbus_master.sv
module sim_mxbus_master;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 12;
    localparam int LEN_W      = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic             req_valid, req_ready, req_write, req_byte;
    logic [15:0]      req_addr, req_wdata;
    logic [LEN_W-1:0] req_len;
    logic             rd_valid;
    logic [15:0]      rd_data;
    logic             done, done_err;
    logic [LEN_W:0]   done_beats;
    logic [15:0]      bus_out, bus_in;
    logic             bus_oe, adr_stb_o, dat_stb_o, dir_wr_o, byte_o, ack_i;

    mxbus_master #(.TMO_CYCLES(TMO), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_byte(req_byte), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_len(req_len), .rd_valid(rd_valid),
        .rd_data(rd_data), .done(done), .done_err(done_err),
        .done_beats(done_beats), .bus_out(bus_out), .bus_oe(bus_oe),
        .bus_in(bus_in), .adr_stb_o(adr_stb_o), .dat_stb_o(dat_stb_o),
        .dir_wr_o(dir_wr_o), .byte_o(byte_o), .ack_i(ack_i)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    int cyc_all = 0;

    // slave and model state
    logic [15:0] smem [0:63];
    logic [15:0] emem [0:63];
    logic [15:0] rdq [$];
    logic [15:0] exp_addr, exp_wdata;
    int  cfg_delay, cfg_silent;
    logic [15:0] slv_addr;
    bit  slv_wr, slv_byte, pend, as_p, ds_p;
    int  cnt, beat, ds_run, as_rises;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_exp(input logic [15:0] w, input bit byt, input bit a0);
        if (!byt) return w;
        return a0 ? {w[7:0], 8'h00} : {8'h00, w[7:0]};
    endfunction

    // Monitor and slave, all at the falling edge
    always @(negedge clk) begin
        if (rst) begin
            ack_i = 1'b0; pend = 0; as_p = 0; ds_p = 0; ds_run = 0; beat = 0;
            slv_addr = '0; bus_in = '0;
        end else begin
            if (dat_stb_o)
                chk(adr_stb_o && (bus_oe == dir_wr_o), "R3 strobe nesting/drive", {adr_stb_o, bus_oe}, {1'b1, dir_wr_o});
            if (adr_stb_o)
                chk(!req_ready, "R1 ready while busy", req_ready, 0);
            if (adr_stb_o && !as_p) begin
                chk(bus_out == exp_addr, "R2 address on lines", bus_out, exp_addr);
                chk(bus_oe && !dat_stb_o, "R2 addr phase strobes", {bus_oe, dat_stb_o}, 2'b10);
                slv_addr = bus_out; slv_wr = dir_wr_o; slv_byte = byte_o; beat = 0;
                as_rises++;
            end
            if (dat_stb_o && !ds_p) begin
                chk(!ack_i, "R4 new phase while reply high", ack_i, 0);
                ds_run = 0;
                if (slv_wr)
                    chk(bus_out == lane_exp(exp_wdata, slv_byte, slv_addr[0]), "R5 write lane data",
                        bus_out, lane_exp(exp_wdata, slv_byte, slv_addr[0]));
                if (cfg_silent < 0 || beat < cfg_silent) begin
                    pend = 1; cnt = cfg_delay;
                end
            end
            if (dat_stb_o) ds_run++;
            if (!dat_stb_o && ds_p && !ack_i)
                chk(ds_run == TMO, "R7 strobe length at timeout", ds_run, TMO);
            if (pend) begin
                if (cnt == 0) begin
                    ack_i = 1'b1; pend = 0;
                    if (slv_wr) begin
                        if (!slv_byte)        smem[slv_addr[6:1]] = bus_out;
                        else if (slv_addr[0]) smem[slv_addr[6:1]][15:8] = bus_out[15:8];
                        else                  smem[slv_addr[6:1]][7:0] = bus_out[7:0];
                    end
                end else cnt--;
            end
            if (!dat_stb_o && ack_i) begin
                ack_i = 1'b0;
                slv_addr = slv_addr + (slv_byte ? 16'd1 : 16'd2);
                beat++;
            end
            bus_in = smem[slv_addr[6:1]];
            if (rd_valid) begin
                if (rdq.size() == 0) chk(0, "R9 unexpected read pulse", rd_data, 0);
                else begin
                    logic [15:0] e;
                    e = rdq.pop_front();
                    chk(rd_data == e, "R9 R5 read data", rd_data, e);
                end
            end
            as_p = adr_stb_o; ds_p = dat_stb_o;
        end
    end

    task automatic xfer(input bit wr, input bit byt, input int addr, input logic [15:0] wd,
                        input int len, input int dly, input int silent, input string tag);
        int nb; bit mis; int a; int w; int r0; bit eerr;
        mis = !byt && (addr % 2 == 1);
        cfg_delay = dly; cfg_silent = silent; exp_wdata = wd; exp_addr = addr[15:0];
        nb = len + 1; eerr = 0;
        if (silent >= 0 && silent <= len) begin nb = silent; eerr = 1; end
        if (mis) begin nb = 0; eerr = 1; end
        a = addr;
        for (int k = 0; k < nb; k++) begin
            int i;
            i = (a / 2) % 64;
            if (wr) begin
                if (!byt)        emem[i] = wd;
                else if (a % 2)  emem[i][15:8] = wd[7:0];
                else             emem[i][7:0] = wd[7:0];
            end else begin
                if (!byt)        rdq.push_back(emem[i]);
                else if (a % 2)  rdq.push_back({8'h00, emem[i][15:8]});
                else             rdq.push_back({8'h00, emem[i][7:0]});
            end
            a += byt ? 1 : 2;
        end
        r0 = as_rises;
        req_write = wr; req_byte = byt; req_addr = addr[15:0]; req_wdata = wd;
        req_len = LEN_W'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        w = 0;
        while (!done && w < 3000) begin @(negedge clk); w++; end
        chk(done, {tag, " done reached"}, done, 1);
        chk(done_err == eerr, {tag, " error flag"}, done_err, eerr);
        chk(done_beats == nb, {tag, " phases completed"}, done_beats, nb);
        if (mis) chk(as_rises == r0, "R8 no address strobe", as_rises - r0, 0);
        @(negedge clk);
        chk(req_ready, "R1 ready after cycle", req_ready, 1);
        chk(rdq.size() == 0, "R9 read pulses missing", rdq.size(), 0);
    endtask

    always @(posedge clk) begin
        cyc_all++;
        if (cyc_all > 50000) begin
            nfail++;
            $display("FAIL R4 watchdog expired actual=%0d expected=<50000", cyc_all);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            smem[i] = 16'h5A00 + 16'(i) * 16'h0103;
            emem[i] = smem[i];
        end
        cfg_delay = 0; cfg_silent = -1; exp_addr = '0; exp_wdata = '0; as_rises = 0;
        rst = 1'b1; req_valid = 0; req_write = 0; req_byte = 0;
        req_addr = '0; req_wdata = '0; req_len = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(req_ready, "R10 ready", req_ready, 1);
        chk(!adr_stb_o && !dat_stb_o && !bus_oe, "R10 strobes idle", {adr_stb_o, dat_stb_o, bus_oe}, 0);
        chk(!done && !rd_valid, "R10 no pulses", {done, rd_valid}, 0);

        xfer(1, 0, 16'h10, 16'hBEEF, 0, 1, -1, "R3 word write");
        xfer(0, 0, 16'h10, 16'h0,    0, 0, -1, "R9 word read back");
        xfer(1, 1, 16'h21, 16'h00C3, 0, 2, -1, "R5 byte write high lane");
        xfer(1, 1, 16'h20, 16'h007E, 0, 0, -1, "R5 byte write low lane");
        xfer(0, 0, 16'h20, 16'h0,    0, 1, -1, "R5 word read of bytes");
        xfer(0, 1, 16'h21, 16'h0,    0, 3, -1, "R5 byte read high lane");
        xfer(0, 1, 16'h20, 16'h0,    0, 0, -1, "R5 byte read low lane");
        xfer(0, 0, 16'h30, 16'h0,    3, 2, -1, "R6 word burst read");
        xfer(1, 1, 16'h41, 16'h55AA, 2, 1, -1, "R6 byte burst write");
        xfer(0, 0, 16'h40, 16'h0,    1, 0, -1, "R6 read after byte burst");
        xfer(1, 0, 16'h50, 16'h1234, 2, 0, -1, "R6 word burst fill");
        xfer(0, 1, 16'h50, 16'h0,    4, 1, -1, "R6 byte burst read");
        xfer(0, 0, 16'h60, 16'h0,    3, 6, -1, "R7 per-phase restart");
        xfer(0, 0, 16'h12, 16'h0,    0, 0,  0, "R7 silent slave");
        xfer(0, 0, 16'h30, 16'h0,    4, 6,  2, "R7 burst partial timeout");
        xfer(1, 0, 16'h70, 16'hAAAA, 3, 1,  1, "R7 write burst timeout");
        xfer(0, 0, 16'h33, 16'h0,    0, 0, -1, "R8 misaligned word");
        xfer(0, 0, 16'h70, 16'h0,    0, 0, -1, "R7 data of completed write");

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule